// File: doc/BRIEF.md
# Decimal Accumulator Processor Core

This block is a small stored-program processor built around one accumulator. Code and data share a single memory of signed bytes. Operation codes and addresses are decimal numbers. An address is formed from two operand bytes as first×100+second, and every arithmetic result is reduced modulo 100. The core runs a fetch-execute loop. It reads an operation code and, when that code is odd, two operand bytes. It then performs the operation, which may include one more memory access for data.

The memory side is a request/acknowledge stream. The core raises `mem_req` together with an address, a direction bit and write data. It holds all of them unchanged until the memory answers with `mem_ack`. This lets the memory apply back-pressure for any number of cycles. Read data is taken in the acknowledge cycle. The display instruction puts an address/value pair on a one-cycle output strobe. An illegal code raises a one-cycle error pulse, and the halt instruction parks the core until reset.

Top module: `dacc_core`

## Requirements
- R1: After reset release, `halted`, `err` and `dsp_valid` are low, and the first memory request is a read (`mem_rw`=1) of address 0.
- R2: Operation codes are: load 91, store 39, clear 8, increment 10, add 99, subtract 61, jump 15, jump-if-zero 17, jump-if-negative 19, display 1, halt 64. An even code is followed by no operand. After an odd code, the next two bytes (at successive program-counter values) form the operand address first×100+second.
- R3: Memory bytes and the accumulator are 8-bit two's complement. Add and subtract read the operand byte and replace the accumulator with the sum or difference reduced modulo 100 by truncated remainder, so the sign follows the unreduced result (-5+-98 gives -3; 99+99 gives 98; -90-30 gives -20).
- R4: Increment adds one under the same rule, so 99 becomes 0.
- R5: After increment, add or subtract, the zero flag is set exactly when the result is 0 and the negative flag exactly when it is below 0. Clear sets the accumulator to 0, sets zero and clears negative.
- R6: Load, store, the three jumps, display and halt leave both flags unchanged, even when the accumulator no longer matches them.
- R7: Jump always continues at the operand address. Jump-if-zero does so only when the zero flag is set, and jump-if-negative only when the negative flag is set. Otherwise execution continues with the next instruction.
- R8: Display reads the operand location and pulses `dsp_valid` for one cycle with `dsp_addr` set to the operand address and `dsp_data` set to the byte read.
- R9: Halt sets `halted`. `halted` stays high until reset, and no memory request follows it.
- R10: A code not in the R2 list pulses `err` for one cycle, and execution carries on with the next fetch. An odd illegal code still consumes its two operand bytes.
- R11: While `mem_req` is high and `mem_ack` is low, `mem_req`, `mem_addr`, `mem_rw` and `mem_wdata` hold their values.
- R12: Store issues a write (`mem_rw`=0) of the accumulator to the operand address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_req | output | 1 | Memory request valid |
| mem_rw | output | 1 | 1 = read, 0 = write |
| mem_addr | output | 14 | Memory address (address register) |
| mem_wdata | output | 8 | Write data (data register), two's complement |
| mem_ack | input | 1 | Memory ready; completes the request, read data valid |
| mem_rdata | input | 8 | Read data, valid with `mem_ack` |
| dsp_valid | output | 1 | One-cycle display strobe |
| dsp_addr | output | 14 | Displayed address |
| dsp_data | output | 8 | Displayed value |
| err | output | 1 | One-cycle illegal-code pulse |
| halted | output | 1 | Core stopped, sticky until reset |

## Verification
The flags are not visible at the ports, and the hardest case is a flag that no longer matches the accumulator. The stimulus reaches it by clearing, then loading a negative value. A zero-flag branch that is still taken and a negative-flag branch that is not taken make the stale flags visible through which display strobes appear. Wrap cases (99+1, 99+99, sums beyond ±100 in both signs) are chained into stores and displays, and the scoreboard compares their values. Each program runs once with an always-ready memory and once with a pseudo-random stalling memory. The stalls exercise the hold rule on every fetch, operand and data access.

// File: rtl/dacc_pkg.sv
package dacc_pkg;

  // operation codes (decimal values are part of the program format)
  localparam int OPC_LOAD  = 91;
  localparam int OPC_STORE = 39;
  localparam int OPC_CLEAR = 8;
  localparam int OPC_INCR  = 10;
  localparam int OPC_ADD   = 99;
  localparam int OPC_SUB   = 61;
  localparam int OPC_JUMP  = 15;
  localparam int OPC_JZERO = 17;
  localparam int OPC_JNEG  = 19;
  localparam int OPC_SHOW  = 1;
  localparam int OPC_STOP  = 64;

  typedef enum logic [3:0] {
    K_LOAD, K_STORE, K_CLEAR, K_INCR, K_ADD, K_SUB,
    K_JUMP, K_JZERO, K_JNEG, K_SHOW, K_STOP, K_BAD
  } op_kind_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_AHI, ST_ALO, ST_EXEC, ST_DATA, ST_STOP
  } state_e;

  typedef enum logic [1:0] {
    ALU_INC, ALU_ADD, ALU_SUB
  } alu_fn_e;

endpackage

// File: rtl/dacc_decode.sv
module dacc_decode
  import dacc_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [DATA_W-1:0] code,
  output op_kind_e          kind
);

  always_comb begin
    unique case (code)
      DATA_W'(OPC_LOAD):  kind = K_LOAD;
      DATA_W'(OPC_STORE): kind = K_STORE;
      DATA_W'(OPC_CLEAR): kind = K_CLEAR;
      DATA_W'(OPC_INCR):  kind = K_INCR;
      DATA_W'(OPC_ADD):   kind = K_ADD;
      DATA_W'(OPC_SUB):   kind = K_SUB;
      DATA_W'(OPC_JUMP):  kind = K_JUMP;
      DATA_W'(OPC_JZERO): kind = K_JZERO;
      DATA_W'(OPC_JNEG):  kind = K_JNEG;
      DATA_W'(OPC_SHOW):  kind = K_SHOW;
      DATA_W'(OPC_STOP):  kind = K_STOP;
      default:            kind = K_BAD;
    endcase
  end

endmodule

// File: rtl/dacc_alu.sv
module dacc_alu
  import dacc_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int RADIX  = 100
) (
  input  alu_fn_e                  fn,
  input  logic signed [DATA_W-1:0] acc_in,
  input  logic signed [DATA_W-1:0] opnd,
  output logic signed [DATA_W-1:0] res,
  output logic                     zero,
  output logic                     neg
);

  // two guard bits hold any sum or difference of two bytes
  localparam int SW = DATA_W + 2;
  localparam logic signed [SW-1:0] MODV = SW'(RADIX);
  localparam logic signed [SW-1:0] ONE  = SW'(1);

  logic signed [SW-1:0] a_w, b_w, raw_w, rem_w;

  always_comb begin
    a_w = {{2{acc_in[DATA_W-1]}}, acc_in};
    b_w = {{2{opnd[DATA_W-1]}}, opnd};
    unique case (fn)
      ALU_INC: raw_w = a_w + ONE;
      ALU_ADD: raw_w = a_w + b_w;
      default: raw_w = a_w - b_w;
    endcase
    // signed remainder truncates toward zero: sign follows raw_w
    rem_w = raw_w % MODV;
  end

  assign res  = rem_w[DATA_W-1:0];
  assign zero = (rem_w == '0);
  assign neg  = rem_w[SW-1];

endmodule

// File: rtl/dacc_core.sv
module dacc_core
  import dacc_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int RADIX    = 100,
  parameter int MAX_ADDR = 9999,
  localparam int ADDR_W  = $clog2(MAX_ADDR + 1),
  localparam int DIGIT_W = $clog2(RADIX)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  output logic                     mem_req,
  output logic                     mem_rw,
  output logic [ADDR_W-1:0]        mem_addr,
  output logic signed [DATA_W-1:0] mem_wdata,
  input  logic                     mem_ack,
  input  logic signed [DATA_W-1:0] mem_rdata,
  output logic                     dsp_valid,
  output logic [ADDR_W-1:0]        dsp_addr,
  output logic signed [DATA_W-1:0] dsp_data,
  output logic                     err,
  output logic                     halted
);

  state_e                   state_q;
  logic [ADDR_W-1:0]        pc_q, mar_q, opaddr_q;
  logic signed [DATA_W-1:0] mdr_q, acc_q;
  logic [DATA_W-1:0]        opc_q;
  logic [DIGIT_W-1:0]       hi_q;
  logic                     z_q, n_q, h_q, rw_q;
  logic                     dsp_v_q, err_q;
  logic [ADDR_W-1:0]        dsp_a_q;
  logic signed [DATA_W-1:0] dsp_d_q;

  op_kind_e                 kind;
  alu_fn_e                  alu_fn;
  logic signed [DATA_W-1:0] alu_res;
  logic                     alu_z, alu_n;
  logic [ADDR_W-1:0]        pc_inc, join_addr;

  dacc_decode #(.DATA_W(DATA_W)) u_dec (
    .code (opc_q),
    .kind (kind)
  );

  always_comb begin
    unique case (kind)
      K_INCR:  alu_fn = ALU_INC;
      K_ADD:   alu_fn = ALU_ADD;
      default: alu_fn = ALU_SUB;
    endcase
  end

  dacc_alu #(.DATA_W(DATA_W), .RADIX(RADIX)) u_alu (
    .fn     (alu_fn),
    .acc_in (acc_q),
    .opnd   (mem_rdata),
    .res    (alu_res),
    .zero   (alu_z),
    .neg    (alu_n)
  );

  // program counter steps through the decimal address space and wraps
  assign pc_inc    = (pc_q == ADDR_W'(MAX_ADDR)) ? '0 : pc_q + 1'b1;
  // operand address: first byte counts hundreds, second byte units
  assign join_addr = ADDR_W'(hi_q) * ADDR_W'(RADIX)
                   + ADDR_W'(mem_rdata[DIGIT_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_OPC;
      pc_q     <= '0;
      mar_q    <= '0;
      opaddr_q <= '0;
      mdr_q    <= '0;
      acc_q    <= '0;
      opc_q    <= '0;
      hi_q     <= '0;
      z_q      <= 1'b0;
      n_q      <= 1'b0;
      h_q      <= 1'b0;
      rw_q     <= 1'b1;
      dsp_v_q  <= 1'b0;
      dsp_a_q  <= '0;
      dsp_d_q  <= '0;
      err_q    <= 1'b0;
    end else begin
      dsp_v_q <= 1'b0;
      err_q   <= 1'b0;
      unique case (state_q)
        ST_OPC: if (mem_ack) begin
          mdr_q <= mem_rdata;
          opc_q <= mem_rdata;
          pc_q  <= pc_inc;
          if (mem_rdata[0]) begin
            mar_q   <= pc_inc;
            state_q <= ST_AHI;
          end else begin
            state_q <= ST_EXEC;
          end
        end
        ST_AHI: if (mem_ack) begin
          mdr_q   <= mem_rdata;
          hi_q    <= mem_rdata[DIGIT_W-1:0];
          pc_q    <= pc_inc;
          mar_q   <= pc_inc;
          state_q <= ST_ALO;
        end
        ST_ALO: if (mem_ack) begin
          mdr_q    <= mem_rdata;
          opaddr_q <= join_addr;
          pc_q     <= pc_inc;
          state_q  <= ST_EXEC;
        end
        ST_EXEC: begin
          unique case (kind)
            K_LOAD, K_ADD, K_SUB, K_SHOW: begin
              mar_q   <= opaddr_q;
              rw_q    <= 1'b1;
              state_q <= ST_DATA;
            end
            K_STORE: begin
              mar_q   <= opaddr_q;
              mdr_q   <= acc_q;
              rw_q    <= 1'b0;
              state_q <= ST_DATA;
            end
            K_CLEAR: begin
              acc_q   <= '0;
              z_q     <= 1'b1;
              n_q     <= 1'b0;
              mar_q   <= pc_q;
              state_q <= ST_OPC;
            end
            K_INCR: begin
              acc_q   <= alu_res;
              z_q     <= alu_z;
              n_q     <= alu_n;
              mar_q   <= pc_q;
              state_q <= ST_OPC;
            end
            K_JUMP, K_JZERO, K_JNEG: begin
              if ((kind == K_JUMP) || (kind == K_JZERO && z_q) ||
                  (kind == K_JNEG && n_q)) begin
                pc_q  <= opaddr_q;
                mar_q <= opaddr_q;
              end else begin
                mar_q <= pc_q;
              end
              state_q <= ST_OPC;
            end
            K_STOP: begin
              h_q     <= 1'b1;
              state_q <= ST_STOP;
            end
            default: begin
              err_q   <= 1'b1;
              mar_q   <= pc_q;
              state_q <= ST_OPC;
            end
          endcase
        end
        ST_DATA: if (mem_ack) begin
          if (rw_q) mdr_q <= mem_rdata;
          unique case (kind)
            K_LOAD: acc_q <= mem_rdata;
            K_ADD, K_SUB: begin
              acc_q <= alu_res;
              z_q   <= alu_z;
              n_q   <= alu_n;
            end
            K_SHOW: begin
              dsp_v_q <= 1'b1;
              dsp_a_q <= mar_q;
              dsp_d_q <= mem_rdata;
            end
            default: ;
          endcase
          mar_q   <= pc_q;
          rw_q    <= 1'b1;
          state_q <= ST_OPC;
        end
        default: ;  // ST_STOP: parked until reset
      endcase
    end
  end

  assign mem_req   = (state_q == ST_OPC) || (state_q == ST_AHI) ||
                     (state_q == ST_ALO) || (state_q == ST_DATA);
  assign mem_rw    = rw_q;
  assign mem_addr  = mar_q;
  assign mem_wdata = mdr_q;
  assign dsp_valid = dsp_v_q;
  assign dsp_addr  = dsp_a_q;
  assign dsp_data  = dsp_d_q;
  assign err       = err_q;
  assign halted    = h_q;

endmodule

// File: rtl/dacc_core_chk.sv
module dacc_core_chk #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     mem_req,
  input logic                     mem_rw,
  input logic [ADDR_W-1:0]        mem_addr,
  input logic signed [DATA_W-1:0] mem_wdata,
  input logic                     mem_ack,
  input logic                     dsp_valid,
  input logic                     err,
  input logic                     halted,
  input logic                     zf,
  input logic                     nf
);

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) &&
                               $stable(mem_rw) && $stable(mem_wdata)));

  // R9
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R9
  halt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> !mem_req);

  // R10
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> !err);

  // R8
  dsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dsp_valid |=> !dsp_valid);

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(zf && nf));

endmodule

bind dacc_core dacc_core_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .mem_req   (mem_req),
  .mem_rw    (mem_rw),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack),
  .dsp_valid (dsp_valid),
  .err       (err),
  .halted    (halted),
  .zf        (z_q),
  .nf        (n_q)
);

// File: tb/sim_dacc_core.sv
`timescale 1ns/1ps
module sim_dacc_core;

  localparam int AW = 14;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic                 mem_req, mem_rw, mem_ack;
  logic [AW-1:0]        mem_addr, dsp_addr;
  logic signed [7:0]    mem_wdata, mem_rdata, dsp_data;
  logic                 dsp_valid, err, halted;

  dacc_core u0 (
    .clk(clk), .rst_n(rst_n),
    .mem_req(mem_req), .mem_rw(mem_rw), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .dsp_valid(dsp_valid), .dsp_addr(dsp_addr), .dsp_data(dsp_data),
    .err(err), .halted(halted)
  );

  int n_checks = 0;
  int n_errs   = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act !== exp) begin
      n_errs++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- memory model with optional stalls ----------------
  logic signed [7:0] mem [0:255];
  logic [15:0] lfsr = 16'hACE1;
  logic stall_en = 1'b0;
  logic ld_clr = 1'b0, ld_en = 1'b0;
  logic [7:0] ld_a = '0;
  logic signed [7:0] ld_v = '0;

  initial begin
    mem_ack   = 1'b0;
    mem_rdata = '0;
  end

  always @(posedge clk) begin
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    if (ld_clr) begin
      for (int i = 0; i < 256; i++) mem[i] <= '0;
    end else if (ld_en) begin
      mem[ld_a] <= ld_v;
    end
    if (!rst_n) mem_ack <= 1'b0;
    else if (mem_ack) mem_ack <= 1'b0;
    else if (mem_req && (!stall_en || lfsr[0])) begin
      mem_ack <= 1'b1;
      if (mem_rw) mem_rdata <= mem[mem_addr[7:0]];
      else        mem[mem_addr[7:0]] <= mem_wdata;
    end
  end

  task automatic put(input int a, input int v);
    @(negedge clk);
    ld_en = 1'b1; ld_a = 8'(a); ld_v = 8'(v);
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic ins(input int a, input int op, input int hi, input int lo);
    put(a, op); put(a + 1, hi); put(a + 2, lo);
  endtask

  // ---------------- scoreboard ----------------
  typedef struct { int a; int d; } show_t;
  show_t exp_q[$];
  int acc_log[$];
  int err_cnt = 0;
  int hs_bad  = 0;

  task automatic expect_show(input int a, input int d);
    show_t s;
    s.a = a; s.d = d;
    exp_q.push_back(s);
  endtask

  always @(negedge clk) begin
    if (rst_n && dsp_valid) begin
      if (exp_q.size() == 0) begin
        check("R8", "unexpected display, addr", int'(dsp_addr), -1);
      end else begin
        show_t s;
        s = exp_q.pop_front();
        check("R8", "display address", int'(dsp_addr), s.a);
        check("R3", "display value", int'(dsp_data), s.d);
      end
    end
    if (rst_n && err) err_cnt++;
    if (rst_n && mem_req && mem_ack && acc_log.size() < 5) acc_log.push_back(int'(mem_addr));
  end

  logic p_req = 1'b0, p_ack = 1'b0, p_rw = 1'b0;
  logic [AW-1:0] p_addr = '0;
  logic signed [7:0] p_wd = '0;
  always @(negedge clk) begin
    if (rst_n && p_req && !p_ack &&
        !(mem_req && mem_addr == p_addr && mem_rw == p_rw && mem_wdata == p_wd))
      hs_bad++;
    p_req = rst_n && mem_req; p_ack = mem_ack; p_rw = mem_rw;
    p_addr = mem_addr; p_wd = mem_wdata;
  end

  // ---------------- programs ----------------
  task automatic load_a();
    ins(0, 91, 2, 0); ins(3, 99, 2, 1); ins(6, 39, 2, 10); ins(9, 1, 2, 10);
    ins(12, 91, 2, 2); ins(15, 61, 2, 1); ins(18, 39, 2, 11); ins(21, 1, 2, 11);
    ins(24, 91, 2, 3); put(27, 10); ins(28, 17, 0, 34); ins(31, 1, 2, 0);
    ins(34, 1, 2, 3); ins(37, 91, 2, 4); ins(40, 61, 2, 5); ins(43, 19, 0, 49);
    put(46, 64); ins(49, 17, 0, 46); ins(52, 39, 2, 12); ins(55, 1, 2, 12);
    put(58, 64);
    put(200, 90); put(201, 30); put(202, -90); put(203, 99); put(204, 50); put(205, 70);
  endtask

  task automatic load_b();
    put(0, 8); ins(1, 91, 2, 0); ins(4, 19, 0, 20); ins(7, 17, 0, 13);
    ins(10, 1, 2, 0); ins(13, 3, 2, 0); put(16, 2); ins(17, 1, 2, 0);
    ins(20, 15, 0, 30); ins(23, 1, 2, 1);
    ins(30, 99, 2, 1); ins(33, 39, 2, 10); put(36, 10); ins(37, 39, 2, 11);
    ins(40, 91, 2, 2); ins(43, 99, 2, 2); ins(46, 39, 2, 12); put(49, 8);
    ins(50, 1, 2, 12); put(53, 64); ins(54, 1, 2, 0);
    put(200, -5); put(201, -98); put(202, 99);
  endtask

  task automatic start(input logic stall, input bit prog_b);
    rst_n = 1'b0;
    stall_en = stall;
    exp_q.delete(); acc_log.delete();
    err_cnt = 0; hs_bad = 0;
    @(negedge clk); ld_clr = 1'b1; @(negedge clk); ld_clr = 1'b0;
    if (prog_b) load_b(); else load_a();
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state seen at the ports
    check("R1", "mem_req after reset", int'(mem_req), 1);
    check("R1", "first access is read", int'(mem_rw), 1);
    check("R1", "first address", int'(mem_addr), 0);
    check("R1", "halted after reset", int'(halted), 0);
    check("R1", "err/dsp after reset", int'(err | dsp_valid), 0);
  endtask

  task automatic finish_run(input int max_cyc);
    int reqs;
    for (int i = 0; i < max_cyc && !halted; i++) @(negedge clk);
    check("R9", "halted reached (watchdog)", int'(halted), 1);
    reqs = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (mem_req) reqs++;
      if (!halted) reqs += 100;
    end
    check("R9", "requests after halt", reqs, 0);
    check("R8", "displays outstanding", exp_q.size(), 0);
    check("R11", "request changed before ack", hs_bad, 0);
  endtask

  task automatic run_a(input logic stall);
    start(stall, 1'b0);
    expect_show(210, 20);   // R3 90+30=120 -> 20
    expect_show(211, -20);  // R3 -90-30 -> -20
    expect_show(203, 99);   // R4/R5/R7 inc 99->0 sets Z, JZ taken
    expect_show(212, -20);  // R5/R7 N set, JN taken, JZ not taken
    finish_run(4000);
    check("R12", "store 210", int'(mem[210]), 20);
    check("R12", "store 211", int'(mem[211]), -20);
    check("R12", "store 212", int'(mem[212]), -20);
    check("R10", "no error pulses", err_cnt, 0);
    check("R2", "access count logged", acc_log.size(), 5);
    if (acc_log.size() == 5) begin
      check("R2", "access 1", acc_log[1], 1);
      check("R2", "access 2", acc_log[2], 2);
      check("R2", "operand address", acc_log[3], 200);
      check("R2", "next opcode", acc_log[4], 3);
    end
  endtask

  task automatic run_b(input logic stall);
    start(stall, 1'b1);
    expect_show(200, -5);   // R6 stale Z after load: JZ taken, JN not
    expect_show(212, 98);   // R3 99+99 -> 98
    finish_run(4000);
    check("R10", "error pulses", err_cnt, 2);
    check("R3", "-5 + -98 stored", int'(mem[210]), -3);
    check("R4", "increment of -3", int'(mem[211]), -2);
    check("R12", "store 212", int'(mem[212]), 98);
    check("R6", "load source untouched", int'(mem[200]), -5);
    if (acc_log.size() == 5) begin
      check("R2", "even code takes no operand", acc_log[1], 1);
      check("R2", "address formed", acc_log[4], 200);
    end else begin
      check("R2", "access count logged", acc_log.size(), 5);
    end
  endtask

  initial begin
    run_a(1'b0);
    run_a(1'b1);
    run_b(1'b0);
    run_b(1'b1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule